// File: doc/BRIEF.md
# Two-Channel Converter Data Front End with Event-Driven Staging

This block is the digital side of a two-channel 12-bit digital-to-analog converter. Each channel holds one active code, which the analog core converts. A write port can load this code in two ways. A direct write replaces the active code and starts a conversion at once. A staged write parks the code in a holding register. A per-channel start event later promotes the held code to the active code, so a timer can pace the conversions at regular intervals.

Each write carries a 16-bit word, and a per-channel setting says whether the 12-bit code sits at the top or at the bottom of that word. Promotion raises a sticky "holding register drained" flag and can also emit a one-cycle event pulse. A start event that finds the holding register empty raises a sticky underrun flag and leaves the active code as it was. Each start event input can respond to its rising edge or to its falling edge. In differential mode, channel 0's event drives both channels. Any conversion start on either channel then starts both channels in the same cycle, with channel 0 as the positive side and channel 1 as the negative side. A per-channel busy counter covers the settling window after each start and flags the end of the conversion when it runs out.

Top module: `dac_pair_front`

## Requirements
- R1: After reset both active codes are 0, all status bits are 0, and the conversion strobes, drain pulses, busy and done outputs are all low.
- R2: The 12-bit code is taken from bits 15:4 of the written word when the channel's left-alignment input is 1, and from bits 11:0 when it is 0. The remaining bits are ignored.
- R3: A direct write to a channel (wr_buffered_i = 0, wr_chan_i selects the channel) shows its code on that channel's code output, and a one-cycle pulse on its conv_start_o bit, in the cycle after the write.
- R4: A staged write (wr_buffered_i = 1) leaves the code outputs unchanged until a start event promotes it.
- R5: A start event on a channel whose holding register is full copies the held code to the active code one cycle later, pulses conv_start_o, and sets that channel's drain status bit. If empty_evt_en for the channel is 1, it also pulses empty_evt_o for one cycle.
- R6: A start event on a channel whose holding register is empty sets that channel's underrun status bit. It leaves the active code unchanged and starts no conversion.
- R7: status_o bit 0 is channel 0 drained, bit 1 is channel 1 drained, bit 2 is channel 0 underrun and bit 3 is channel 1 underrun. Each bit stays set until status_clr_i writes a 1 to it. A set in the same cycle as a clear wins.
- R8: A start event is the 0-to-1 change of start_evt_i for a channel whose fall-edge input is 0, and the 1-to-0 change for a channel whose fall-edge input is 1. Each edge is seen on the clock cycle in which the input first carries its new level.
- R9: When diff_mode_i is 1, channel 0's start event acts on both channels and channel 1's event input is ignored. Any conversion start on either channel pulses conv_start_o on both channels in the same cycle.
- R10: After each conversion start, busy_o for that channel is high for exactly CONV_CYCLES cycles. The channel's done output then rises and stays high until the next start.
- R11: A staged write marks the holding register full again. When a staged write and a promoting event fall in the same cycle, the old held code is promoted and the new one is kept as full.
- R12: When a promoting event and a direct write hit the same channel in the same cycle, the promoted code wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Write strobe |
| wr_chan_i | input | 1 | Channel addressed by the write |
| wr_buffered_i | input | 1 | 1 = staged write, 0 = direct write |
| wr_data_i | input | 16 | Written data word |
| left_adj_i | input | 2 | Per-channel code alignment (1 = bits 15:4) |
| fall_edge_i | input | 2 | Per-channel event edge select (1 = falling) |
| empty_evt_en_i | input | 2 | Per-channel drain event enable |
| diff_mode_i | input | 1 | Lock-step differential mode |
| start_evt_i | input | 2 | Per-channel start event inputs |
| status_clr_i | input | 4 | Write-1-to-clear for status bits |
| code0_o | output | 12 | Channel 0 active code |
| code1_o | output | 12 | Channel 1 active code |
| conv_start_o | output | 2 | Per-channel conversion start strobe |
| empty_evt_o | output | 2 | Per-channel drain event pulse |
| busy_o | output | 2 | Per-channel conversion window active |
| eoc_o | output | 2 | Per-channel conversion done |
| status_o | output | 4 | Sticky status flags |

## Verification
The bench builds the block with CONV_CYCLES = 5. A window that short lets random event traffic land often on a channel that is still busy, and lets the end of a window coincide with a fresh start, so the restart and done paths both get exercised many times. The bench also toggles the differential mode, the edge polarity and the alignment mid-run. This brings into reach the cases where the two channels are out of step when lock-step begins, and where an event input is already low when falling-edge mode is selected.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
    localparam int CODE_W = 12;
    localparam int WORD_W = 16;
    localparam int NCH    = 2;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t code;
        code_t stage;
        logic  full;
        logic  conv;
        logic  eevt;
        logic  eoc;
    } chan_regs_t;
endpackage

// File: rtl/dpf_edge.sv
module dpf_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic fall_i,
    output logic trig_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = evt_i;
        trig_o = fall_i ? (prev_q & ~evt_i) : (evt_i & ~prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/dpf_chan.sv
module dpf_chan
    import dpf_pkg::*;
#(
    parameter int CONV_CYCLES = 16,
    localparam int CNT_W = $clog2(CONV_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              left_adj_i,
    input  logic              wr_dir_i,
    input  logic              wr_buf_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              trig_i,
    input  logic              evt_en_i,
    input  logic              go_i,
    output logic              start_req_o,
    output logic              promote_o,
    output logic              underrun_o,
    output code_t             code_o,
    output logic              conv_o,
    output logic              eevt_o,
    output logic              busy_o,
    output logic              eoc_o
);
    chan_regs_t r_d, r_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;
    code_t fmt;

    always_comb begin
        fmt         = left_adj_i ? wr_data_i[WORD_W-1 -: CODE_W] : wr_data_i[CODE_W-1:0];
        promote_o   = trig_i & r_q.full;
        underrun_o  = trig_i & ~r_q.full;
        start_req_o = promote_o | wr_dir_i;

        r_d = r_q;
        if (promote_o)     r_d.code = r_q.stage;
        else if (wr_dir_i) r_d.code = fmt;
        if (wr_buf_i)       begin r_d.stage = fmt; r_d.full = 1'b1; end
        else if (promote_o) r_d.full = 1'b0;
        r_d.conv = go_i;
        r_d.eevt = promote_o & evt_en_i;

        if (go_i)              cnt_d = CNT_W'(CONV_CYCLES);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else                   cnt_d = cnt_q;

        if (go_i)                       r_d.eoc = 1'b0;
        else if (cnt_q == CNT_W'(1))    r_d.eoc = 1'b1;

        code_o = r_q.code;
        conv_o = r_q.conv;
        eevt_o = r_q.eevt;
        eoc_o  = r_q.eoc;
        busy_o = (cnt_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q   <= '0;
            cnt_q <= '0;
        end else begin
            r_q   <= r_d;
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/dac_pair_front.sv
module dac_pair_front
    import dpf_pkg::*;
#(
    parameter int CONV_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_valid_i,
    input  logic        wr_chan_i,
    input  logic        wr_buffered_i,
    input  logic [15:0] wr_data_i,
    input  logic [1:0]  left_adj_i,
    input  logic [1:0]  fall_edge_i,
    input  logic [1:0]  empty_evt_en_i,
    input  logic        diff_mode_i,
    input  logic [1:0]  start_evt_i,
    input  logic [3:0]  status_clr_i,
    output logic [11:0] code0_o,
    output logic [11:0] code1_o,
    output logic [1:0]  conv_start_o,
    output logic [1:0]  empty_evt_o,
    output logic [1:0]  busy_o,
    output logic [1:0]  eoc_o,
    output logic [3:0]  status_o
);
    logic [NCH-1:0] raw_trig, trig, start_req, go, promote, underrun;
    code_t          code [NCH];
    logic [3:0]     stat_d, stat_q;

    always_comb begin
        trig[0] = raw_trig[0];
        trig[1] = diff_mode_i ? raw_trig[0] : raw_trig[1];
        for (int i = 0; i < NCH; i++)
            go[i] = diff_mode_i ? (|start_req) : start_req[i];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit = wr_valid_i && (wr_chan_i == 1'(g));

        dpf_edge u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_i  (start_evt_i[g]),
            .fall_i (fall_edge_i[g]),
            .trig_o (raw_trig[g])
        );

        dpf_chan #(.CONV_CYCLES(CONV_CYCLES)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .left_adj_i  (left_adj_i[g]),
            .wr_dir_i    (hit && !wr_buffered_i),
            .wr_buf_i    (hit && wr_buffered_i),
            .wr_data_i   (wr_data_i),
            .trig_i      (trig[g]),
            .evt_en_i    (empty_evt_en_i[g]),
            .go_i        (go[g]),
            .start_req_o (start_req[g]),
            .promote_o   (promote[g]),
            .underrun_o  (underrun[g]),
            .code_o      (code[g]),
            .conv_o      (conv_start_o[g]),
            .eevt_o      (empty_evt_o[g]),
            .busy_o      (busy_o[g]),
            .eoc_o       (eoc_o[g])
        );
    end

    always_comb begin
        stat_d   = (stat_q & ~status_clr_i) | {underrun, promote};
        status_o = stat_q;
        code0_o  = code[0];
        code1_o  = code[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end
endmodule

// File: rtl/dac_pair_front_chk.sv
module dac_pair_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       diff_mode_i,
    input logic [3:0] status_clr_i,
    input logic [1:0] conv_start_o,
    input logic [1:0] empty_evt_o,
    input logic [1:0] busy_o,
    input logic [1:0] eoc_o,
    input logic [3:0] status_o
);
    // R10
    conv_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o[0] |-> busy_o[0]);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_o[1] |-> !busy_o[1]);
    // R10
    fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o[0]) |-> eoc_o[0]);
    // R5
    drain_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_evt_o[1] |-> status_o[1]);
    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_o[2]) && !$past(status_clr_i[2])) |-> status_o[2]);
    // R9
    lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(diff_mode_i) |-> (conv_start_o[0] == conv_start_o[1]));
endmodule

bind dac_pair_front dac_pair_front_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .diff_mode_i  (diff_mode_i),
    .status_clr_i (status_clr_i),
    .conv_start_o (conv_start_o),
    .empty_evt_o  (empty_evt_o),
    .busy_o       (busy_o),
    .eoc_o        (eoc_o),
    .status_o     (status_o)
);

// File: tb/dac_pair_front_bench.sv
`timescale 1ns/1ps
module dac_pair_front_bench;
    localparam int NCYC = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_valid = 0, wr_chan = 0, wr_buffered = 0;
    logic [15:0] wr_data = '0;
    logic [1:0] left_adj = '0, fall_edge = '0, eevt_en = '0, start_evt = '0;
    logic diff = 1'b0;
    logic [3:0] clr = '0;
    logic [11:0] code0, code1;
    logic [1:0] conv, eevt, busy, eoc;
    logic [3:0] status;

    int vectors = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dac_pair_front #(.CONV_CYCLES(NCYC)) u_dac_pair_front (
        .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid), .wr_chan_i(wr_chan),
        .wr_buffered_i(wr_buffered), .wr_data_i(wr_data), .left_adj_i(left_adj),
        .fall_edge_i(fall_edge), .empty_evt_en_i(eevt_en), .diff_mode_i(diff),
        .start_evt_i(start_evt), .status_clr_i(clr), .code0_o(code0), .code1_o(code1),
        .conv_start_o(conv), .empty_evt_o(eevt), .busy_o(busy), .eoc_o(eoc),
        .status_o(status)
    );

    // reference model state
    logic [11:0] m_code [2], m_stage [2], n_code [2], n_stage [2];
    logic [1:0]  m_full, m_conv, m_eevt, m_eoc, m_prev;
    logic [1:0]  n_full, n_conv, n_eevt, n_eoc, n_prev;
    int          m_cnt [2], n_cnt [2];
    logic [3:0]  m_stat, n_stat;

    function automatic logic [11:0] pick(input logic [15:0] w, input logic left);
        return left ? w[15:4] : w[11:0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_code[i] = '0; m_stage[i] = '0; m_cnt[i] = 0;
        end
        m_full = '0; m_conv = '0; m_eevt = '0; m_eoc = '0; m_prev = '0; m_stat = '0;
    endtask

    task automatic model_next();
        logic [1:0] raw, trg, prom, und, sreq, wd, wb;
        for (int i = 0; i < 2; i++) begin
            raw[i] = fall_edge[i] ? (m_prev[i] & ~start_evt[i]) : (start_evt[i] & ~m_prev[i]);
            wd[i] = wr_valid && (wr_chan == 1'(i)) && !wr_buffered;
            wb[i] = wr_valid && (wr_chan == 1'(i)) && wr_buffered;
        end
        trg = {diff ? raw[0] : raw[1], raw[0]};
        for (int i = 0; i < 2; i++) begin
            prom[i] = trg[i] & m_full[i];
            und[i]  = trg[i] & ~m_full[i];
            sreq[i] = prom[i] | wd[i];
        end
        for (int i = 0; i < 2; i++) begin
            logic g;
            g = diff ? (|sreq) : sreq[i];
            n_code[i]  = prom[i] ? m_stage[i] : (wd[i] ? pick(wr_data, left_adj[i]) : m_code[i]);
            n_stage[i] = wb[i] ? pick(wr_data, left_adj[i]) : m_stage[i];
            n_full[i]  = wb[i] ? 1'b1 : (prom[i] ? 1'b0 : m_full[i]);
            n_conv[i]  = g;
            n_eevt[i]  = prom[i] & eevt_en[i];
            n_cnt[i]   = g ? NCYC : (m_cnt[i] > 0 ? m_cnt[i] - 1 : 0);
            n_eoc[i]   = g ? 1'b0 : (m_cnt[i] == 1 ? 1'b1 : m_eoc[i]);
            n_prev[i]  = start_evt[i];
        end
        n_stat = (m_stat & ~clr) | {und, prom};
    endtask

    task automatic model_commit();
        for (int i = 0; i < 2; i++) begin
            m_code[i] = n_code[i]; m_stage[i] = n_stage[i]; m_cnt[i] = n_cnt[i];
        end
        m_full = n_full; m_conv = n_conv; m_eevt = n_eevt; m_eoc = n_eoc;
        m_prev = n_prev; m_stat = n_stat;
    endtask

    task automatic compare();
        chk("R2/R3/R4/R6/R9/R12 code0", 32'(code0), 32'(m_code[0]));
        chk("R2/R3/R4/R6/R9/R12 code1", 32'(code1), 32'(m_code[1]));
        chk("R3/R5/R8/R9 conv_start", 32'(conv), 32'(m_conv));
        chk("R5/R11 empty_evt", 32'(eevt), 32'(m_eevt));
        chk("R10 busy", 32'(busy), {30'b0, m_cnt[1] > 0, m_cnt[0] > 0});
        chk("R10 eoc", 32'(eoc), 32'(m_eoc));
        chk("R5/R6/R7/R11 status", 32'(status), 32'(m_stat));
    endtask

    // inputs are driven at the falling edge; outputs checked at the next falling edge
    task automatic tick();
        model_next();
        @(posedge clk);
        model_commit();
        @(negedge clk);
        compare();
        wr_valid = 0; clr = '0;
    endtask

    task automatic wr(input logic ch, input logic bufd, input logic [15:0] d);
        wr_valid = 1; wr_chan = ch; wr_buffered = bufd; wr_data = d;
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 code0", 32'(code0), 0);
        chk("R1 code1", 32'(code1), 0);
        chk("R1 status", 32'(status), 0);
        chk("R1 strobes", {26'b0, conv, eevt, busy}, 0);
        chk("R1 eoc", 32'(eoc), 0);
        rst_n = 1;
        eevt_en = 2'b11;

        // R2 right alignment, R3 direct write
        wr(0, 0, 16'hFABC); tick();
        chk("R2/R3 direct right", 32'(code0), 32'hABC);
        chk("R3 strobe", 32'(conv), 32'b01);
        // R2 left alignment
        left_adj = 2'b10; wr(1, 0, 16'h5A3F); tick();
        chk("R2 direct left", 32'(code1), 32'h5A3);
        // R6 underrun on empty holding register
        start_evt[0] = 1; tick();
        chk("R6 underrun bit", 32'(status[2]), 1);
        chk("R6 code kept", 32'(code0), 32'hABC);
        chk("R6 no start", 32'(conv[0]), 0);
        start_evt[0] = 0; tick();
        // R4 staged write held
        wr(0, 1, 16'h0123); tick();
        chk("R4 held", 32'(code0), 32'hABC);
        // R5 promotion
        start_evt[0] = 1; tick();
        chk("R5 promoted", 32'(code0), 32'h123);
        chk("R5 drain bit", 32'(status[0]), 1);
        chk("R5 drain evt", 32'(eevt[0]), 1);
        start_evt[0] = 0; tick();
        // R7 set beats clear in same cycle
        start_evt[0] = 1; clr = 4'b0100; tick();
        chk("R7 set wins", 32'(status[2]), 1);
        clr = 4'b0101; tick();
        chk("R7 cleared", 32'(status & 4'b0101), 0);
        start_evt[0] = 0;
        // R10 window length
        repeat (NCYC) tick();
        chk("R10 done after window", 32'(eoc[0]), 1);
        // R8 falling edge select
        fall_edge[1] = 1; wr(1, 1, 16'h7770); tick();
        start_evt[1] = 1; tick();
        chk("R8 rise ignored", 32'(conv[1]), 0);
        start_evt[1] = 0; tick();
        chk("R8 fall triggers", 32'(code1), 32'h777);
        // R9 lock step, R11/R12 collisions
        diff = 1; fall_edge = 2'b00; wr(1, 1, 16'h0440); tick();
        start_evt[1] = 1; tick();
        chk("R9 ch1 event ignored", 32'(conv), 0);
        start_evt[0] = 1; wr(0, 1, 16'h0055); tick();
        chk("R9 both start", 32'(conv), 32'b11);
        chk("R11 ch1 promoted", 32'(code1), 32'h044);
        start_evt = '0; tick();
        diff = 0; start_evt[0] = 1; wr(0, 0, 16'h0999); tick();
        chk("R12 promotion over direct", 32'(code0), 32'h055);
        start_evt = '0; tick();

        // constrained random phase
        for (int c = 0; c < 4000; c++) begin
            if (c % 250 == 0) begin
                left_adj = 2'($urandom); fall_edge = 2'($urandom);
                eevt_en = 2'($urandom); diff = ($urandom % 3) == 0;
            end
            if ($urandom % 10 < 3) wr(1'($urandom), 1'($urandom), 16'($urandom));
            for (int i = 0; i < 2; i++)
                if ($urandom % 4 == 0) start_evt[i] = ~start_evt[i];
            if ($urandom % 16 == 0) clr = 4'($urandom);
            tick();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule